// File: doc/BRIEF.md
# Dicode Hysteresis Threshold Detector

This block turns a sampled three-level dicode channel stream back into NRZ bits. On such a channel, a bit transition shows up as a short positive or negative pulse. A run of equal bits shows up as no pulse at all.

Each valid signed sample is compared against a threshold whose sign is picked by the bit decided last. After a 0, only a positive pulse above the threshold can change the output. After a 1, only a negative pulse below the negated threshold can change it. Any other sample repeats the previous bit, so the output holds between pulses. The decision made on one sample applies to the very next sample.

The threshold magnitude is an unsigned value that can be written directly. It can also be trained at the start of each burst. A burst-start pulse presets the decided bit and can open a training window of a fixed number of valid samples. During that window the block records the largest sample magnitude. When the window closes, the threshold becomes half that peak, rounded down.

Top module: `dicode_hyst_detector`

## Requirements
- R1: After reset, `bit_out` is 0, `bit_valid` is 0, `training` is 0 and `thr_level` equals the parameter `THR_INIT`.
- R2: Every valid sample, except one taken in a burst-start cycle, yields exactly one `bit_valid` pulse in the following cycle. Cycles without a valid sample yield no pulse.
- R3: While the decided bit is 0, a sample strictly greater than `thr_level` (signed compare) sets it to 1. Any other sample, including negative ones, leaves it at 0.
- R4: While the decided bit is 1, a sample strictly less than minus `thr_level` clears it to 0. Any other sample, including positive ones, leaves it at 1.
- R5: Each decision uses the bit decided from the immediately preceding valid sample, including on back-to-back samples.
- R6: A cycle with `thr_wr` high loads `thr_wdata` into `thr_level` on the next cycle.
- R7: A `burst_start` cycle sets the decided bit to `init_bit` and ignores any sample in that cycle (no `bit_valid`). It also sets `training` to `train_en` and restarts the peak search from zero. It leaves `thr_level` unchanged.
- R8: While `training` is high, the `PRE_LEN`-th valid sample loads `thr_level` with floor(max |sample| / 2) over the window and clears `training`. Invalid cycles do not count toward the window.
- R9: The most negative sample code, -2^(SW-1), counts as magnitude 2^(SW-1) in the peak search.
- R10: When the final training sample and `thr_wr` fall in the same cycle, the trained value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SW | Two's-complement channel sample |
| burst_start | input | 1 | Start of a new burst |
| init_bit | input | 1 | Decided-bit value preset at burst start |
| train_en | input | 1 | Open a training window at burst start |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | SW | Threshold value to write |
| bit_out | output | 1 | Current decided bit |
| bit_valid | output | 1 | One pulse per decided sample |
| thr_level | output | SW | Threshold magnitude in use |
| training | output | 1 | Training window open |

## Verification
The bench builds the block with 8-bit samples, a training window of 4 samples and an initial threshold of 20. With these values, samples at the threshold and one step above it can be applied directly. The code -128 is reachable, so the full-scale magnitude of 128 is exercised. A training window can be completed, with gaps, within a handful of cycles, and the same-cycle collision between a threshold write and the end of training can be forced.

// File: rtl/dicode_hyst_detector.sv
module dicode_hyst_detector #(
  parameter int SW       = 8,
  parameter int PRE_LEN  = 16,
  parameter int THR_INIT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          burst_start,
  input  logic          init_bit,
  input  logic          train_en,
  input  logic          thr_wr,
  input  logic [SW-1:0] thr_wdata,
  output logic          bit_out,
  output logic          bit_valid,
  output logic [SW-1:0] thr_level,
  output logic          training
);
  localparam int CW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_LEN - 1);

  logic signed [SW:0] sx, nsx, thr_s, nthr_s;
  logic [SW-1:0] mag, peak, peak_nx;
  logic [CW-1:0] cnt;
  logic take, hit_pos, hit_neg, done;

  assign take    = smp_valid && !burst_start;
  assign sx      = {smp_data[SW-1], smp_data};
  assign nsx     = -sx;
  assign mag     = smp_data[SW-1] ? nsx[SW-1:0] : smp_data;
  assign thr_s   = {1'b0, thr_level};
  assign nthr_s  = -thr_s;
  assign hit_pos = sx > thr_s;
  assign hit_neg = sx < nthr_s;
  assign peak_nx = (mag > peak) ? mag : peak;
  assign done    = take && training && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= take;
      if (burst_start)
        bit_out <= init_bit;
      else if (smp_valid)
        bit_out <= bit_out ? !hit_neg : hit_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_level <= SW'(THR_INIT);
      training  <= 1'b0;
      cnt       <= '0;
      peak      <= '0;
    end else if (burst_start) begin
      training <= train_en;
      cnt      <= '0;
      peak     <= '0;
      if (thr_wr) thr_level <= thr_wdata;
    end else begin
      if (done) begin
        thr_level <= peak_nx >> 1;
        training  <= 1'b0;
      end else if (thr_wr) begin
        thr_level <= thr_wdata;
      end
      if (take && training) begin
        peak <= peak_nx;
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

module dicode_hyst_detector_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [SW-1:0] smp_data,
  input logic          burst_start,
  input logic          bit_out,
  input logic          bit_valid,
  input logic [SW-1:0] thr_level,
  input logic          training
);
  assert_valid_follows_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(smp_valid) && !$past(burst_start)));

  assert_hold_without_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smp_valid) && !$past(burst_start)) |-> $stable(bit_out));

  assert_rise_needs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bit_out) && !$past(burst_start)) |->
      ($signed($past(smp_data)) > $signed({1'b0, $past(thr_level)})));

  assert_fall_needs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bit_out) && !$past(burst_start)) |->
      ($signed($past(smp_data)) < -$signed({1'b0, $past(thr_level)})));

  assert_train_ends_on_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(training) && !$past(burst_start)) |-> $past(smp_valid));
endmodule

bind dicode_hyst_detector dicode_hyst_detector_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .burst_start(burst_start), .bit_out(bit_out), .bit_valid(bit_valid),
  .thr_level(thr_level), .training(training)
);

// File: tb/test_dicode_hyst_detector.sv
module test_dicode_hyst_detector;
  localparam int SW = 8;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, burst_start = 0, init_bit = 0, train_en = 0, thr_wr = 0;
  logic [SW-1:0] smp_data = '0, thr_wdata = '0;
  logic bit_out, bit_valid, training;
  logic [SW-1:0] thr_level;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dicode_hyst_detector #(.SW(SW), .PRE_LEN(4), .THR_INIT(20)) i_dicode_hyst_detector (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .burst_start(burst_start), .init_bit(init_bit), .train_en(train_en),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .bit_out(bit_out),
    .bit_valid(bit_valid), .thr_level(thr_level), .training(training));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic v, int d, logic bs = 0, logic ib = 0, logic te = 0,
                      logic w = 0, int wd = 0);
    @(negedge clk);
    smp_valid = v; smp_data = SW'(d); burst_start = bs; init_bit = ib;
    train_en = te; thr_wr = w; thr_wdata = SW'(wd);
    @(negedge clk);
    smp_valid = 0; burst_start = 0; thr_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 bit_out", bit_out, 0);
    chk("R1 bit_valid", bit_valid, 0);
    chk("R1 training", training, 0);
    chk("R1 thr_level", thr_level, 20);
  endtask

  task automatic t_levels();
    step(1, 20);  chk("R3 equal holds 0", bit_out, 0); chk("R2 valid pulse", bit_valid, 1);
    step(1, -90); chk("R3 negative holds 0", bit_out, 0);
    step(1, 21);  chk("R3 above sets 1", bit_out, 1);
    step(1, 60);  chk("R4 positive holds 1", bit_out, 1);
    step(1, -20); chk("R4 equal holds 1", bit_out, 1);
    step(0, -90); chk("R2 no sample no pulse", bit_valid, 0);
    chk("R2 no sample holds", bit_out, 1);
    step(1, -21); chk("R4 below clears", bit_out, 0);
  endtask

  task automatic t_b2b();
    @(negedge clk); smp_valid = 1; smp_data = SW'(30);
    @(negedge clk); chk("R5 b2b 1", bit_out, 1); smp_data = SW'(-30);
    @(negedge clk); chk("R5 b2b 2", bit_out, 0); smp_data = SW'(30);
    @(negedge clk); chk("R5 b2b 3", bit_out, 1); smp_data = SW'(30);
    @(negedge clk); chk("R5 b2b 4", bit_out, 1); chk("R2 b2b valid", bit_valid, 1);
    smp_valid = 0;
    step(1, -40); chk("R5 back to 0", bit_out, 0);
  endtask

  task automatic t_write();
    step(0, 0, 0, 0, 0, 1, 50); chk("R6 thr written", thr_level, 50);
    step(1, 40); chk("R6 below new thr holds", bit_out, 0);
    step(1, 51); chk("R6 above new thr sets", bit_out, 1);
  endtask

  task automatic t_train();
    step(1, 100, 1, 0, 1);
    chk("R7 preset 0", bit_out, 0); chk("R7 sample ignored", bit_valid, 0);
    chk("R7 training on", training, 1); chk("R7 thr kept", thr_level, 50);
    step(1, 10); step(0, 0); step(1, -40); step(1, 25);
    chk("R8 still training", training, 1); chk("R8 thr unchanged", thr_level, 50);
    step(1, 5);
    chk("R8 training done", training, 0); chk("R8 thr trained", thr_level, 20);
    step(1, 21); chk("R8 trained thr used", bit_out, 1);
  endtask

  task automatic t_fullscale();
    step(0, 0, 1, 1, 1);
    chk("R7 preset 1", bit_out, 1);
    step(1, -128); step(1, 0); step(1, 3); step(1, 0);
    chk("R9 full scale peak", thr_level, 64);
    chk("R9 window closed", training, 0);
  endtask

  task automatic t_collide();
    step(0, 0, 1, 0, 1);
    step(1, 30); step(1, 30); step(1, 30);
    step(1, 30, 0, 0, 0, 1, 99);
    chk("R10 training wins", thr_level, 15);
    step(0, 0, 1, 1, 0);
    chk("R7 no train", training, 0); chk("R7 init 1", bit_out, 1);
    chk("R7 thr kept", thr_level, 15);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_b2b();
    t_write();
    t_train();
    t_fullscale();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule